// File: doc/BRIEF.md
# Cascadable Serial Channel Programmer

This block receives 16-bit command words over a three-wire serial port (an active-low frame enable, a serial clock and a data line) and uses them to load a bank of eight 10-bit target codes plus a refresh-clock source select. It runs entirely on one system clock: the three serial pins are brought through synchronizers and their edges are found in the system clock domain, so the serial clock must be several times slower than the system clock.

Every rising serial clock edge inside a frame pushes one data bit into a 16-bit shift register, most significant bit first. When the enable line returns high, the register is decoded once. The top bit marks a test word, the next bit picks the refresh-clock source (0 internal, 1 external), the following four bits address a channel (only the low three are decoded), and the low ten bits are the code. A buffered copy of the register's oldest bit leaves on a falling serial clock edge. Several blocks can share one port by chaining the serial output of one into the serial input of the next. They share the clock and enable, and the host sends one word per device in a single frame, farthest device first.

Top module: `serial_chan_prog`

## Requirements
- R1: After reset all eight channel codes are 0, the clock-source output is 0 (internal), the programmed flag is 0 and the serial output is 0.
- R2: While the enable pin is low, each rising serial clock edge shifts the data pin into bit 0 of the shift register and moves every older bit one place up, so the first bit of a word ends in bit 15.
- R3: Serial clock edges that occur while the enable pin is high change neither the shift register nor the serial output.
- R4: On a rising edge of the enable pin with bit 15 of the register at 0, the code field (bits 9..0) is written into the channel that bits 12..10 select (0 to 7); bit 13 has no effect on the choice, and the other channels keep their codes.
- R5: A word committed with bit 15 at 1 writes no channel code.
- R6: Every commit, test word or not, copies bit 14 into the clock-source output and sets the programmed flag, which then stays set until reset.
- R7: The serial output changes only on falling serial clock edges inside a frame, where it takes bit 15 of the register; a bit presented with rising edge k of a frame leaves on falling edge k+15.
- R8: When a frame carries more than 16 bits, only the last 16 bits received are decoded at the commit.
- R9: A frame with fewer than 16 serial clock edges still commits, decoding whatever the shift register then holds.
- R10: A pin change first sampled at system clock edge k takes effect on the outputs at edge k+2 (the enable rise for R4 to R6, serial clock edges for R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial bit clock, asynchronous to clk |
| serDin | input | 1 | Serial data in |
| serEnN | input | 1 | Frame enable, low while a frame is sent |
| serDout | output | 1 | Serial data out for the next device in a chain |
| chanCodes | output | 80 | Eight 10-bit channel codes, channel n in bits 10n+9..10n |
| oscExt | output | 1 | Refresh-clock source: 0 internal, 1 external |
| modeProgrammed | output | 1 | Set by the first commit after reset |

## Verification
Each pin change is first sampled at one system clock edge, and the register it drives changes two edges later. A commit therefore shows on the code, clock-source and flag outputs at the third edge counted from the one that first sees the enable rise, and the serial output moves at the third edge counted from the one that first sees a serial clock fall. The bench holds every pin level for four system clocks and keeps a behavioural model with the same pin-to-output delay. It compares all outputs with that model at every falling system clock edge, so each result is looked at in exactly the cycle it is due. Directed checks at the end of each frame pin down the expected codes, the chained output bits and the edge before and after a commit.

// File: rtl/serial_chan_prog_pkg.sv
package serial_chan_prog_pkg;

  // One-cycle strobes from the pin front end to the word datapath
  typedef struct packed {
    logic shift;   // rising serial clock inside a frame
    logic fall;    // falling serial clock inside a frame
    logic commit;  // enable returned high
  } serStrobe_t;

endpackage

// File: rtl/serial_chan_prog_ctrl.sv
module serial_chan_prog_ctrl
  import serial_chan_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serDin,
  input  logic       serEnN,
  output serStrobe_t strobe,
  output logic       dinBit
);

  // One stage beyond the synchronizer keeps the previous level for edge detection
  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES:0]   enPipe;
  logic [SYNC_STAGES-1:0] dinPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      enPipe  <= '1;
      dinPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], serClk};
      enPipe  <= {enPipe[SYNC_STAGES-1:0], serEnN};
      dinPipe <= {dinPipe[SYNC_STAGES-2:0], serDin};
    end
  end

  logic clkNow, clkOld, enNow, enOld;
  assign clkNow = clkPipe[SYNC_STAGES-1];
  assign clkOld = clkPipe[SYNC_STAGES];
  assign enNow  = enPipe[SYNC_STAGES-1];
  assign enOld  = enPipe[SYNC_STAGES];

  always_comb begin
    strobe.shift  = clkNow && !clkOld && !enNow;
    strobe.fall   = !clkNow && clkOld && !enNow;
    strobe.commit = enNow && !enOld;
  end

  assign dinBit = dinPipe[SYNC_STAGES-1];

endmodule

// File: rtl/serial_chan_prog_dp.sv
module serial_chan_prog_dp
  import serial_chan_prog_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int CODE_W   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  serStrobe_t                 strobe,
  input  logic                       dinBit,
  output logic                       serDout,
  output logic [NUM_CHAN*CODE_W-1:0] chanFlat,
  output logic                       oscExt,
  output logic                       modeProgrammed
);

  localparam int ADDR_W       = $clog2(NUM_CHAN);
  localparam int ADDR_FIELD_W = 4;
  localparam int WORD_W       = CODE_W + ADDR_FIELD_W + 2;
  localparam int TEST_BIT     = WORD_W - 1;
  localparam int OSC_BIT      = WORD_W - 2;

  logic [WORD_W-1:0] shReg;
  logic [CODE_W-1:0] chanReg [NUM_CHAN];
  logic [ADDR_W-1:0] wordAddr;
  logic              wordIsTest;
  logic              writeEn;

  assign wordAddr   = shReg[CODE_W +: ADDR_W];
  assign wordIsTest = shReg[TEST_BIT];
  assign writeEn    = strobe.commit && !wordIsTest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      serDout <= 1'b0;
    end else begin
      if (strobe.shift) shReg   <= {shReg[WORD_W-2:0], dinBit};
      if (strobe.fall)  serDout <= shReg[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscExt         <= 1'b0;
      modeProgrammed <= 1'b0;
    end else if (strobe.commit) begin
      oscExt         <= shReg[OSC_BIT];
      modeProgrammed <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chanReg[g] <= '0;
      else if (writeEn && wordAddr == ADDR_W'(g)) chanReg[g] <= shReg[CODE_W-1:0];
    end
    assign chanFlat[g*CODE_W +: CODE_W] = chanReg[g];
  end

  // R2: a shift strobe moves the whole word up and appends the sampled bit
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> shReg == {$past(shReg[WORD_W-2:0]), $past(dinBit)});

  // R3/R7: the serial output moves only on a falling strobe
  a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fall |=> $stable(serDout));

  // R4: a normal commit lands the code in the addressed channel
  a_r4_write_addr: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |=> chanReg[$past(wordAddr)] == $past(shReg[CODE_W-1:0]));

  // R5: a test word leaves every channel untouched
  a_r5_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wordIsTest) |=> $stable(chanFlat));

  // R6: every commit copies the clock-source bit and sets the flag
  a_r6_osc_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (oscExt == $past(shReg[OSC_BIT])) && modeProgrammed);

  // R6: the flag never clears outside reset
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeProgrammed |=> modeProgrammed);

endmodule

// File: rtl/serial_chan_prog.sv
module serial_chan_prog
  import serial_chan_prog_pkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serDin,
  input  logic                       serEnN,
  output logic                       serDout,
  output logic [NUM_CHAN*CODE_W-1:0] chanCodes,
  output logic                       oscExt,
  output logic                       modeProgrammed
);

  serStrobe_t strobe;
  logic       dinBit;

  serial_chan_prog_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serDin (serDin),
    .serEnN (serEnN),
    .strobe (strobe),
    .dinBit (dinBit)
  );

  serial_chan_prog_dp #(
    .NUM_CHAN(NUM_CHAN),
    .CODE_W  (CODE_W)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .dinBit         (dinBit),
    .serDout        (serDout),
    .chanFlat       (chanCodes),
    .oscExt         (oscExt),
    .modeProgrammed (modeProgrammed)
  );

endmodule

// File: tb/tb_serial_chan_prog.sv
module tb_serial_chan_prog;

  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serDin = 1'b0;
  logic        serEnN = 1'b1;
  logic        serDout;
  logic [79:0] chanCodes;
  logic        oscExt;
  logic        modeProgrammed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_chan_prog dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDin), .serEnN(serEnN),
    .serDout(serDout), .chanCodes(chanCodes), .oscExt(oscExt),
    .modeProgrammed(modeProgrammed)
  );

  // ---------------- behavioural reference model ----------------
  int  mCode [8];
  bit  mOsc, mProg, mDout;
  bit  bitsQ [$];
  bit  pClk [3];
  bit  pEn  [3];
  bit  pDin [2];

  function automatic logic [15:0] packWord();
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[15-k] = bitsQ[k];
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mCode[i] = 0;
      mOsc = 0; mProg = 0; mDout = 0;
      bitsQ = {};
      for (int i = 0; i < 16; i++) bitsQ.push_back(1'b0);
      pClk = '{0, 0, 0}; pEn = '{1, 1, 1}; pDin = '{0, 0};
    end else begin
      bit rise, fall, commit;
      logic [15:0] w;
      rise   = pClk[1] && !pClk[2] && !pEn[1];
      fall   = !pClk[1] && pClk[2] && !pEn[1];
      commit = pEn[1] && !pEn[2];
      w = packWord();
      if (commit) begin
        if (!w[15]) mCode[w[12:10]] = int'(w[9:0]);
        mOsc  = w[14];
        mProg = 1;
      end
      if (fall) mDout = bitsQ[0];
      if (rise) begin
        bitsQ.push_back(pDin[1]);
        void'(bitsQ.pop_front());
      end
      pClk[2] = pClk[1]; pClk[1] = pClk[0]; pClk[0] = serClk;
      pEn[2]  = pEn[1];  pEn[1]  = pEn[0];  pEn[0]  = serEnN;
      pDin[1] = pDin[0]; pDin[0] = serDin;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int code(input int ch);
    return int'(chanCodes[ch*10 +: 10]);
  endfunction

  // Compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 8; i++)
        check(code(i) == mCode[i], "R4/R5/R10 model channel code", code(i), mCode[i]);
      check(oscExt == mOsc, "R6/R10 model clock source", oscExt, mOsc);
      check(modeProgrammed == mProg, "R6 model programmed flag", modeProgrammed, mProg);
      check(serDout == mDout, "R7/R10 model serial out", serDout, mDout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    serDin = b;  waitClk(HOLD);
    serClk = 1;  waitClk(HOLD);
    serClk = 0;  waitClk(HOLD);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) sendBit(v[k]);
  endtask

  task automatic openFrame();
    serEnN = 0; waitClk(HOLD);
  endtask

  task automatic closeFrame();
    serEnN = 1; waitClk(8);
  endtask

  function automatic logic [15:0] mkWord(input bit t, input bit o, input int a, input int d);
    return {t, o, 4'(a), 10'(d)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitClk(5);
    rstN = 1;
    waitClk(3);
    // R1: reset state
    for (int i = 0; i < 8; i++) check(code(i) == 0, "R1 reset code", code(i), 0);
    check(oscExt == 0, "R1 reset clock source", oscExt, 0);
    check(modeProgrammed == 0, "R1 reset flag", modeProgrammed, 0);
    check(serDout == 0, "R1 reset serial out", serDout, 0);

    // R2/R4: channel 2 gets 513, internal source
    openFrame(); sendBits(32'(mkWord(0, 0, 2, 513)), 16); closeFrame();
    check(code(2) == 513, "R2/R4 channel 2 code", code(2), 513);
    check(modeProgrammed == 1, "R6 flag set", modeProgrammed, 1);
    check(oscExt == 0, "R6 internal source", oscExt, 0);

    // R4: address bit 13 ignored, channel 7 gets 31, external source
    openFrame(); sendBits(32'(mkWord(0, 1, 15, 31)), 16); closeFrame();
    check(code(7) == 31, "R4 channel 7 with bit 13 set", code(7), 31);
    check(code(2) == 513, "R4 other channel kept", code(2), 513);
    check(oscExt == 1, "R6 external source", oscExt, 1);

    // R5: test word writes nothing, still copies source bit
    openFrame(); sendBits(32'(mkWord(1, 0, 2, 5)), 16); closeFrame();
    check(code(2) == 513, "R5 test word no write", code(2), 513);
    check(oscExt == 0, "R5/R6 test word source bit", oscExt, 0);
    check(modeProgrammed == 1, "R6 flag stays set", modeProgrammed, 1);

    // R10: channel 5 gets 1, external source; sample around the commit edge
    openFrame(); sendBits(32'(mkWord(0, 1, 5, 1)), 16);
    serEnN = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(code(5) == 0, "R10 no update after two edges", code(5), 0);
    @(negedge clk);
    check(code(5) == 1, "R10 update at third edge", code(5), 1);
    waitClk(8);

    // R3: serial clock pulses with the enable high, then an empty frame
    for (int k = 0; k < 3; k++) sendBit(1'b1);
    check(serDout == 0, "R3 serial out unchanged", serDout, 0);
    openFrame(); closeFrame();
    check(code(0) == 0, "R3 no shift while enable high", code(0), 0);
    check(oscExt == 1, "R3 same word committed", oscExt, 1);

    // R9: six-bit frame commits shifted contents: channel 0 gets 115
    openFrame(); sendBits(32'b110011, 6); closeFrame();
    check(code(0) == 115, "R9 short frame commit", code(0), 115);
    check(oscExt == 0, "R9 short frame source bit", oscExt, 0);

    // R7/R8: 32-bit chained frame; first word is for a farther device
    openFrame();
    begin
      logic [31:0] pair;
      pair = {mkWord(1, 0, 6, 700), mkWord(0, 1, 4, 300)};
      for (int k = 31; k >= 0; k--) begin
        sendBit(pair[k]);
        if (k == 16) check(serDout == 1, "R7 first bit out on 16th fall", serDout, 1);
        if (k == 15) check(serDout == 0, "R7 second bit out on 17th fall", serDout, 0);
      end
    end
    closeFrame();
    check(code(4) == 300, "R8 last word committed", code(4), 300);
    check(code(6) == 0, "R8 first word not committed", code(6), 0);
    check(oscExt == 1, "R8 last word source bit", oscExt, 1);

    waitClk(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule